// File: doc/BRIEF.md
# Power-Sourcing Controller Interrupt Summary Unit

This block gathers event pulses from a four-port power-sourcing controller into five sticky 8-bit event registers. Each register has two nibbles. The low nibble holds one event type for ports 0 to 3, and the high nibble holds a second event type for the same ports. The exception is the startup-fault and supply-fault registers, whose bits are all summarised together. The eight event classes are folded into an 8-bit summary byte. That byte is ANDed with a mask register and gated by a global enable bit to drive an active-low interrupt pin.

Software reaches the unit through a plain register port with an address, write data, a write strobe and combinational read data. Through this port it can read the summary and the event registers, read and write the mask, toggle the global enable, and issue a single clear-all write that wipes every event at once. After an interrupt, a handler reads the summary byte to find the event class, reads the matching event register to find the port, and then clears.

Top module: `pse_irq_hub`

## Requirements
- R1: `irq_n` is 0 exactly when the global enable is 1 and at least one summary bit that has its mask bit set is 1. Otherwise `irq_n` is 1. The pin is a combinational function of the registered state.
- R2: The summary byte at address 00h is built as follows. Bit 0 is the OR of power event bits 3:0. Bit 1 is the OR of power event bits 7:4. Bit 2 is the OR of fault event bits 7:4. Bit 3 is the OR of detect/class event bits 3:0. Bit 4 is the OR of detect/class event bits 7:4. Bit 5 is the OR of fault event bits 3:0. Bit 6 is the OR of all startup event bits. Bit 7 is the OR of all supply event bits.
- R3: Event bits are sticky. A 1 on an event input bit at a clock edge sets that register bit, and the bit stays set until a clear-all or a reset.
- R4: A write to address 1Ah with `wdata[7]`=1 clears all five event registers, and therefore the summary, at that edge. The clear wins over a set in the same cycle. A write to 1Ah with `wdata[7]`=0 changes nothing.
- R5: The mask register at address 01h reads back the last value written to it.
- R6: The global enable is bit 7 of address 17h, and it reads back in that bit with all other bits 0. While it is 0, `irq_n` stays 1 whatever the events are.
- R7: While `rst` is high at an edge, all event registers clear and the global enable becomes 1. The mask loads {A,A,A,0,0,A,0,0} (bit 7 to bit 0), where A is `auto_mode` sampled at the previous edge. This gives E4h for A=1 and 00h for A=0.
- R8: The summary byte is read-only, so writes to 00h have no effect. Address 1Ah always reads 00h, and unused addresses read 00h.
- R9: The event registers read back at these addresses: power at 02h, detect/class at 03h, fault at 04h, startup at 05h and supply at 06h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_mode | input | 1 | Mode level that selects the mask reset pattern |
| ev_pwr | input | 8 | Power-enable change pulses [3:0], power-good change pulses [7:4] |
| ev_detcls | input | 8 | Detection done pulses [3:0], classification done pulses [7:4] |
| ev_flt | input | 8 | Current-limit pulses [3:0], load-disconnect pulses [7:4] |
| ev_start | input | 8 | Startup fault pulses |
| ev_sup | input | 8 | Supply fault pulses |
| addr | input | 5 | Register address |
| wdata | input | 8 | Register write data |
| we | input | 1 | Write strobe, one write per high cycle |
| rdata | output | 8 | Combinational read data for `addr` |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The clocked properties assume that `rst`, `we`, `addr`, `wdata` and the event inputs are stable around each rising edge. They also assume that reset is held for at least two edges, so that the sampled `auto_mode` is defined before the mask loads. The bench changes every input only on falling edges and holds `auto_mode` steady across each reset. It then mixes sparse random event pulses with random writes, including clear-all writes and writes to read-only addresses.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int DW     = 8;
    localparam int NREG   = 5;
    localparam int AW     = 5;
    localparam int HALF   = DW / 2;

    localparam logic [AW-1:0] A_SUM    = 5'h00;
    localparam logic [AW-1:0] A_MASK   = 5'h01;
    localparam logic [AW-1:0] A_EVBASE = 5'h02;
    localparam logic [AW-1:0] A_GEN    = 5'h17;
    localparam logic [AW-1:0] A_CLR    = 5'h1A;
    localparam int            GEN_BIT  = 7;
    localparam int            CLR_BIT  = 7;

    typedef enum logic [2:0] {
        EVR_PWR    = 3'd0,
        EVR_DETCLS = 3'd1,
        EVR_FLT    = 3'd2,
        EVR_START  = 3'd3,
        EVR_SUP    = 3'd4
    } evreg_e;

    typedef logic [NREG-1:0][DW-1:0] evbank_t;

    typedef struct packed {
        logic sup;
        logic start;
        logic ilim;
        logic cls;
        logic det;
        logic disc;
        logic pgood;
        logic pen;
    } sum_t;

    function automatic logic [DW-1:0] mask_rst_val(input logic a);
        return {a, a, a, 1'b0, 1'b0, a, 1'b0, 1'b0};
    endfunction

endpackage

// File: rtl/pirq_evt_bank.sv
module pirq_evt_bank
    import pirq_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = DW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_i,
    input  logic [N-1:0][W-1:0] set_i,
    output logic [N-1:0][W-1:0] ev_o
);

    logic [N-1:0][W-1:0] ev_q;

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                ev_q[g] <= '0;
            end else begin
                ev_q[g] <= ev_q[g] | set_i[g];
            end
        end
    end

    assign ev_o = ev_q;

    // R3: no bit drops without a clear
    a_r3_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

    // R3: every pulsed bit is captured
    a_r3_capture: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((ev_q & $past(set_i)) == $past(set_i)));

    // R4: clear-all beats a same-cycle set
    a_r4_clear_all: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (ev_q == '0));

endmodule

// File: rtl/pirq_sum_reduce.sv
module pirq_sum_reduce
    import pirq_pkg::*;
(
    input  evbank_t ev_i,
    output sum_t    sum_o
);

    always_comb begin
        sum_o.pen   = |ev_i[EVR_PWR][HALF-1:0];
        sum_o.pgood = |ev_i[EVR_PWR][DW-1:HALF];
        sum_o.det   = |ev_i[EVR_DETCLS][HALF-1:0];
        sum_o.cls   = |ev_i[EVR_DETCLS][DW-1:HALF];
        sum_o.ilim  = |ev_i[EVR_FLT][HALF-1:0];
        sum_o.disc  = |ev_i[EVR_FLT][DW-1:HALF];
        sum_o.start = |ev_i[EVR_START];
        sum_o.sup   = |ev_i[EVR_SUP];
    end

endmodule

// File: rtl/pirq_ctl_regs.sv
module pirq_ctl_regs
    import pirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          auto_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] sum_i,
    input  evbank_t       ev_i,
    output logic          clr_o,
    output logic [DW-1:0] mask_o,
    output logic          gen_o,
    output logic [DW-1:0] rdata_o
);

    logic          auto_q;
    logic [DW-1:0] mask_q;
    logic          gen_q;

    always_ff @(posedge clk) begin
        auto_q <= auto_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= mask_rst_val(auto_q);
            gen_q  <= 1'b1;
        end else if (we_i) begin
            if (addr_i == A_MASK) mask_q <= wdata_i;
            if (addr_i == A_GEN)  gen_q  <= wdata_i[GEN_BIT];
        end
    end

    assign clr_o  = we_i && (addr_i == A_CLR) && wdata_i[CLR_BIT];
    assign mask_o = mask_q;
    assign gen_o  = gen_q;

    always_comb begin
        rdata_o = '0;
        if (addr_i == A_SUM) begin
            rdata_o = sum_i;
        end else if (addr_i == A_MASK) begin
            rdata_o = mask_q;
        end else if (addr_i == A_GEN) begin
            rdata_o[GEN_BIT] = gen_q;
        end
        for (int i = 0; i < NREG; i++) begin
            if (addr_i == A_EVBASE + AW'(i)) rdata_o = ev_i[i];
        end
    end

    // R5: mask write lands
    a_r5_mask_write: assert property (@(posedge clk) disable iff (rst)
        (we_i && addr_i == A_MASK) |=> (mask_q == $past(wdata_i)));

    // R6: enable write lands
    a_r6_gen_write: assert property (@(posedge clk) disable iff (rst)
        (we_i && addr_i == A_GEN) |=> (gen_q == $past(wdata_i[GEN_BIT])));

endmodule

// File: rtl/pirq_irq_gate.sv
module pirq_irq_gate
    import pirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] sum_i,
    input  logic [DW-1:0] mask_i,
    input  logic          gen_i,
    output logic          irq_n_o
);

    logic [DW-1:0] live;

    assign live    = sum_i & mask_i;
    assign irq_n_o = ~(gen_i & (|live));

    // R6: disabled pin stays high
    a_r6_gate_off: assert property (@(posedge clk) disable iff (rst)
        !gen_i |-> irq_n_o);

endmodule

// File: rtl/pse_irq_hub.sv
module pse_irq_hub
    import pirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          auto_mode,
    input  logic [DW-1:0] ev_pwr,
    input  logic [DW-1:0] ev_detcls,
    input  logic [DW-1:0] ev_flt,
    input  logic [DW-1:0] ev_start,
    input  logic [DW-1:0] ev_sup,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          we,
    output logic [DW-1:0] rdata,
    output logic          irq_n
);

    evbank_t       set_w;
    evbank_t       ev_w;
    sum_t          sum_s;
    logic [DW-1:0] sum_w;
    logic [DW-1:0] mask_w;
    logic          gen_w;
    logic          clr_w;

    always_comb begin
        set_w             = '0;
        set_w[EVR_PWR]    = ev_pwr;
        set_w[EVR_DETCLS] = ev_detcls;
        set_w[EVR_FLT]    = ev_flt;
        set_w[EVR_START]  = ev_start;
        set_w[EVR_SUP]    = ev_sup;
    end

    pirq_evt_bank #(.N(NREG), .W(DW)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .clr_i (clr_w),
        .set_i (set_w),
        .ev_o  (ev_w)
    );

    pirq_sum_reduce u_red (
        .ev_i  (ev_w),
        .sum_o (sum_s)
    );

    assign sum_w = sum_s;

    pirq_ctl_regs u_ctl (
        .clk     (clk),
        .rst     (rst),
        .auto_i  (auto_mode),
        .we_i    (we),
        .addr_i  (addr),
        .wdata_i (wdata),
        .sum_i   (sum_w),
        .ev_i    (ev_w),
        .clr_o   (clr_w),
        .mask_o  (mask_w),
        .gen_o   (gen_w),
        .rdata_o (rdata)
    );

    pirq_irq_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .sum_i   (sum_w),
        .mask_i  (mask_w),
        .gen_i   (gen_w),
        .irq_n_o (irq_n)
    );

    // R1: an enabled, unmasked summary bit pulls the pin low
    a_r1_fires: assert property (@(posedge clk) disable iff (rst)
        (gen_w && ((sum_w & mask_w) != '0)) |-> !irq_n);

    // R8: with no events the summary reads zero
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
        ((ev_w == '0) && (addr == A_SUM)) |-> (rdata == '0));

endmodule

// File: tb/sim_pse_irq_hub.sv
module sim_pse_irq_hub;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       auto_mode = 1'b1;
    logic [7:0] evin [5];
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       we = 1'b0;
    logic [7:0] rdata;
    logic       irq_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    pse_irq_hub u0 (
        .clk       (clk),
        .rst       (rst),
        .auto_mode (auto_mode),
        .ev_pwr    (evin[0]),
        .ev_detcls (evin[1]),
        .ev_flt    (evin[2]),
        .ev_start  (evin[3]),
        .ev_sup    (evin[4]),
        .addr      (addr),
        .wdata     (wdata),
        .we        (we),
        .rdata     (rdata),
        .irq_n     (irq_n)
    );

    // behavioural reference
    logic [7:0] m_ev [5];
    logic [7:0] m_mask;
    logic       m_gen;
    logic       m_auto_prev;

    function automatic logic [7:0] ref_sum();
        logic [7:0] s;
        s[0] = |m_ev[0][3:0];
        s[1] = |m_ev[0][7:4];
        s[2] = |m_ev[2][7:4];
        s[3] = |m_ev[1][3:0];
        s[4] = |m_ev[1][7:4];
        s[5] = |m_ev[2][3:0];
        s[6] = |m_ev[3];
        s[7] = |m_ev[4];
        return s;
    endfunction

    function automatic logic [7:0] ref_rd(input logic [4:0] a);
        if (a == 5'h00) return ref_sum();
        if (a == 5'h01) return m_mask;
        if (a == 5'h17) return {m_gen, 7'b0};
        if (a >= 5'h02 && a <= 5'h06) return m_ev[a - 5'h02];
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        logic clr;
        if (rst) begin
            for (int i = 0; i < 5; i++) m_ev[i] = 8'h00;
            m_mask = {m_auto_prev, m_auto_prev, m_auto_prev, 2'b00, m_auto_prev, 2'b00};
            m_gen  = 1'b1;
        end else begin
            clr = we && (addr == 5'h1A) && wdata[7];
            for (int i = 0; i < 5; i++) m_ev[i] = clr ? 8'h00 : (m_ev[i] | evin[i]);
            if (we && addr == 5'h01) m_mask = wdata;
            if (we && addr == 5'h17) m_gen = wdata[7];
        end
        m_auto_prev = auto_mode;
    end

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // compare with the model every cycle
    always begin
        @(posedge clk);
        #(CLK_P/4);
        if (!rst && !done) begin
            logic exp_irq;
            exp_irq = !(m_gen && ((ref_sum() & m_mask) != 8'h00));
            chk(irq_n === exp_irq, "R1 model irq_n", {7'b0, irq_n}, {7'b0, exp_irq});
            chk(rdata === ref_rd(addr), "R2/R9 model rdata", rdata, ref_rd(addr));
        end
    end

    task automatic idle_inputs();
        for (int i = 0; i < 5; i++) evin[i] = 8'h00;
        we = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        idle_inputs();
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v, output logic pin);
        @(negedge clk);
        idle_inputs();
        addr = a;
        @(posedge clk);
        #(CLK_P/4);
        v = rdata; pin = irq_n;
    endtask

    task automatic pulse(input int r, input logic [7:0] v);
        @(negedge clk);
        idle_inputs();
        evin[r] = v;
        @(negedge clk);
        evin[r] = 8'h00;
    endtask

    task automatic do_reset(input logic a);
        @(negedge clk);
        idle_inputs();
        auto_mode = a;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic       p;
        int         regs [8] = '{0, 0, 2, 1, 1, 2, 3, 4};
        int         bits [8] = '{0, 5, 6, 2, 7, 1, 3, 4};

        idle_inputs();
        repeat (2) @(negedge clk);
        do_reset(1'b1);

        rd(5'h01, v, p); chk(v == 8'hE4, "R7 mask reset A=1", v, 8'hE4);
        rd(5'h00, v, p); chk(v == 8'h00, "R7 summary reset", v, 8'h00);
        rd(5'h17, v, p); chk(v == 8'h80, "R7 enable reset", v, 8'h80);
        chk(p == 1'b1, "R7 pin idle", {7'b0, p}, 8'h01);

        // R2 and R9: one event per summary bit
        for (int k = 0; k < 8; k++) begin
            wr(5'h1A, 8'h80);
            pulse(regs[k], 8'(1 << bits[k]));
            rd(5'h00, v, p);
            chk(v == 8'(1 << k), "R2 summary bit map", v, 8'(1 << k));
            rd(5'(2 + regs[k]), v, p);
            chk(v == 8'(1 << bits[k]), "R9 event readback", v, 8'(1 << bits[k]));
        end

        // R1: mask E4 blocks bit 0, passes bit 7
        wr(5'h1A, 8'h80);
        pulse(0, 8'h01);
        rd(5'h00, v, p); chk(p == 1'b1, "R1 masked bit quiet", {7'b0, p}, 8'h01);
        pulse(4, 8'h10);
        rd(5'h00, v, p); chk(p == 1'b0, "R1 unmasked bit fires", {7'b0, p}, 8'h00);

        // R6: global enable
        wr(5'h17, 8'h7F);
        rd(5'h17, v, p); chk(v == 8'h00, "R6 enable readback", v, 8'h00);
        chk(p == 1'b1, "R6 disabled pin high", {7'b0, p}, 8'h01);
        wr(5'h17, 8'h80);
        rd(5'h00, v, p); chk(p == 1'b0, "R6 re-enabled pin low", {7'b0, p}, 8'h00);

        // R3: stickiness
        wr(5'h1A, 8'h80);
        pulse(2, 8'h04);
        repeat (5) @(negedge clk);
        rd(5'h04, v, p); chk(v == 8'h04, "R3 sticky hold", v, 8'h04);
        pulse(2, 8'h10);
        rd(5'h04, v, p); chk(v == 8'h14, "R3 accumulate", v, 8'h14);

        // R4: clear without bit 7 is a no-op, then clear beats set
        wr(5'h1A, 8'h7F);
        rd(5'h04, v, p); chk(v == 8'h14, "R4 no-op clear", v, 8'h14);
        @(negedge clk);
        idle_inputs();
        evin[4] = 8'hFF; addr = 5'h1A; wdata = 8'h80; we = 1'b1;
        @(negedge clk);
        idle_inputs();
        rd(5'h06, v, p); chk(v == 8'h00, "R4 clear wins", v, 8'h00);
        rd(5'h04, v, p); chk(v == 8'h00, "R4 all cleared", v, 8'h00);
        rd(5'h00, v, p); chk(v == 8'h00, "R4 summary cleared", v, 8'h00);

        // R5: mask read/write
        wr(5'h01, 8'h5A);
        rd(5'h01, v, p); chk(v == 8'h5A, "R5 mask readback", v, 8'h5A);

        // R8: read-only summary and clear location
        wr(5'h00, 8'hFF);
        rd(5'h00, v, p); chk(v == 8'h00, "R8 summary write ignored", v, 8'h00);
        rd(5'h1A, v, p); chk(v == 8'h00, "R8 clear reads zero", v, 8'h00);
        rd(5'h0C, v, p); chk(v == 8'h00, "R8 unused reads zero", v, 8'h00);

        // random traffic, compared each cycle with the model
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            for (int i = 0; i < 5; i++)
                evin[i] = ($urandom % 12 == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
            we = ($urandom % 6 == 0);
            case ($urandom % 7)
                0: addr = 5'h00;
                1: addr = 5'h01;
                2: addr = 5'h17;
                3: addr = 5'h1A;
                default: addr = 5'($urandom % 8);
            endcase
            wdata = 8'($urandom);
            if (addr == 5'h1A && ($urandom % 4 != 0)) wdata[7] = 1'b0;
        end
        idle_inputs();

        // R7: reset with mode low
        do_reset(1'b0);
        rd(5'h01, v, p); chk(v == 8'h00, "R7 mask reset A=0", v, 8'h00);
        rd(5'h06, v, p); chk(v == 8'h00, "R7 events reset", v, 8'h00);
        rd(5'h17, v, p); chk(v == 8'h80, "R7 enable reset again", v, 8'h80);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule